// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This block holds four registers of equal width that share one internal data bus. A two-bit source code picks the register that drives the bus. Each register has its own load enable and copies the bus value on a clock edge. One common condition input gates every move, so a load takes place only on an edge where that condition is 1. A separate exchange command swaps two chosen registers on one edge. An external parallel word can take the place of the register source on the bus, which is how data first enters the bank.

The bus is a multiplexer for each bit. A parameter chooses how the source is selected: an indexed multiplexer, or a two-to-four decoder with an enable that AND-ORs the register words. Both choices give the same values at the ports. The whole bus and all four registers are visible as outputs.

The external word uses a valid/ready handshake. A word is taken in any cycle where `ext_valid` and `ext_ready` are both high. `ext_ready` is high in every cycle outside reset, so back-pressure only happens during reset. The sender may raise `ext_valid` without first waiting for ready. Data is not stored anywhere unless a load enable is also active in that cycle.

Top module: `bus_xfer_unit`

## Requirements
- R1: When `rst` is high at a clock edge, all four registers become zero. `ext_ready` is low while `rst` is high.
- R2: With `bus_en`=1 and no external word taken, `bus_o` equals register A for `src_sel`=00, B for 01, C for 10 and D for 11. Register index 0 is A and index 3 is D.
- R3: With `bus_en`=0 and no external word taken, `bus_o` is all zeros. No register drives the bus.
- R4: `ext_ready` is 1 in every cycle where `rst` is 0. In a cycle where `ext_valid` and `ext_ready` are both 1, `bus_o` equals `ext_data`, whatever `src_sel` and `bus_en` are.
- R5: At an edge where `cond`=1 and bit i of `ld_en` is 1, register i takes the value `bus_o` had before the edge. This holds unless register i is part of an exchange. When several bits are set, every enabled register takes that same value.
- R6: At an edge where `cond`=0, no register changes. This covers both loads and exchanges.
- R7: At an edge where `cond`=1 and `xchg_req`=1 with `xchg_a`≠`xchg_b`, the two named registers swap their contents on that one edge.
- R8: An exchange has priority over a bus load for the two registers it names. Any other register whose load bit is set still takes the bus value on the same edge.
- R9: An exchange where `xchg_a`=`xchg_b` leaves that register unchanged, even when its load bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Code of the register that drives the bus |
| bus_en | input | 1 | Enables register drive onto the bus |
| ld_en | input | 4 | Load enable for each register, bit 0 = A |
| cond | input | 1 | Control condition that gates every transfer |
| xchg_req | input | 1 | Exchange request |
| xchg_a | input | 2 | First register of the exchange |
| xchg_b | input | 2 | Second register of the exchange |
| ext_valid | input | 1 | External word offered |
| ext_ready | output | 1 | External word can be accepted |
| ext_data | input | W | External parallel word |
| bus_o | output | W | Present value of the shared bus |
| regs_o | output | 4×W | Register contents, element i = register i |

## Verification
A corrupted register shows up on `regs_o` on the first falling edge after the edge that corrupted it. It also shows up on `bus_o` in the next cycle that selects that register. A fault in the select decode or in the enable gating shows up on `bus_o` in the same cycle, before any clock edge. A wrong priority between exchange and load, or a load that ignores the condition, is seen one edge after the command. The sweeps read every register after every cycle, so no fault can stay hidden past the cycle that follows it.

// File: rtl/bus_xfer_pkg.sv
package bus_xfer_pkg;
  localparam int SEL_W   = 2;
  localparam int REG_CNT = 1 << SEL_W;
  localparam int STYLE_MUX = 0;
  localparam int STYLE_DEC = 1;
endpackage

// File: rtl/bus_xfer_src_sel.sv
module bus_xfer_src_sel
  import bus_xfer_pkg::*;
#(
  parameter int W     = 8,
  parameter int STYLE = STYLE_MUX
) (
  input  logic [REG_CNT-1:0][W-1:0] regs_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic                      en_i,
  output logic [W-1:0]              bus_o
);
  generate
    if (STYLE == STYLE_DEC) begin : g_dec
      logic [REG_CNT-1:0] drive_oh;
      always_comb begin
        drive_oh = '0;
        if (en_i) drive_oh[sel_i] = 1'b1;
      end
      always_comb begin
        bus_o = '0;
        for (int i = 0; i < REG_CNT; i++)
          bus_o = bus_o | (regs_i[i] & {W{drive_oh[i]}});
      end
    end else begin : g_mux
      for (genvar b = 0; b < W; b++) begin : g_bit
        logic [REG_CNT-1:0] column;
        for (genvar i = 0; i < REG_CNT; i++) begin : g_in
          assign column[i] = regs_i[i][b];
        end
        assign bus_o[b] = en_i & column[sel_i];
      end
    end
  endgenerate
endmodule

// File: rtl/bus_xfer_slot.sv
module bus_xfer_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] bus_i,
  input  logic         swap_i,
  input  logic [W-1:0] swap_val_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (swap_i) q_o <= swap_val_i;
    else if (load_i) q_o <= bus_i;
  end
endmodule

// File: rtl/bus_xfer_unit.sv
module bus_xfer_unit
  import bus_xfer_pkg::*;
#(
  parameter int W     = 8,
  parameter int STYLE = STYLE_MUX
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SEL_W-1:0]          src_sel,
  input  logic                      bus_en,
  input  logic [REG_CNT-1:0]        ld_en,
  input  logic                      cond,
  input  logic                      xchg_req,
  input  logic [SEL_W-1:0]          xchg_a,
  input  logic [SEL_W-1:0]          xchg_b,
  input  logic                      ext_valid,
  output logic                      ext_ready,
  input  logic [W-1:0]              ext_data,
  output logic [W-1:0]              bus_o,
  output logic [REG_CNT-1:0][W-1:0] regs_o
);
  logic [W-1:0] reg_bus;
  logic         ext_take;

  assign ext_ready = ~rst;
  assign ext_take  = ext_valid & ext_ready;

  bus_xfer_src_sel #(.W(W), .STYLE(STYLE)) src_i (
    .regs_i(regs_o), .sel_i(src_sel), .en_i(bus_en), .bus_o(reg_bus)
  );

  assign bus_o = ext_take ? ext_data : reg_bus;

  generate
    for (genvar i = 0; i < REG_CNT; i++) begin : g_slot
      logic         is_a, is_b, swap, load;
      logic [W-1:0] partner;
      assign is_a    = (xchg_a == SEL_W'(i));
      assign is_b    = (xchg_b == SEL_W'(i));
      assign swap    = cond & xchg_req & (is_a | is_b);
      assign load    = cond & ld_en[i];
      assign partner = is_a ? regs_o[xchg_b] : regs_o[xchg_a];
      bus_xfer_slot #(.W(W)) slot_i (
        .clk(clk), .rst(rst), .load_i(load), .bus_i(bus_o),
        .swap_i(swap), .swap_val_i(partner), .q_o(regs_o[i])
      );
    end
  endgenerate
endmodule

// File: rtl/bus_xfer_chk.sv
module bus_xfer_chk
  import bus_xfer_pkg::*;
#(
  parameter int W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [SEL_W-1:0]          src_sel,
  input logic                      bus_en,
  input logic [REG_CNT-1:0]        ld_en,
  input logic                      cond,
  input logic                      xchg_req,
  input logic [SEL_W-1:0]          xchg_a,
  input logic [SEL_W-1:0]          xchg_b,
  input logic                      ext_valid,
  input logic                      ext_ready,
  input logic [W-1:0]              ext_data,
  input logic [W-1:0]              bus_o,
  input logic [REG_CNT-1:0][W-1:0] regs_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (regs_o == '0));

  // R3
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_en && !ext_valid) |-> (bus_o == '0));

  // R4
  ext_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_valid && ext_ready) |-> (bus_o == ext_data));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cond |=> $stable(regs_o));

  // R7
  swap_chk: assert property (@(posedge clk) disable iff (rst)
    (cond && xchg_req && xchg_a != xchg_b) |=>
      (regs_o[$past(xchg_a)] == $past(regs_o[xchg_b]) &&
       regs_o[$past(xchg_b)] == $past(regs_o[xchg_a])));

  generate
    for (genvar i = 0; i < REG_CNT; i++) begin : g_r
      // R5 R8
      load_chk: assert property (@(posedge clk) disable iff (rst)
        (cond && ld_en[i] &&
         !(xchg_req && (xchg_a == SEL_W'(i) || xchg_b == SEL_W'(i))))
          |=> (regs_o[i] == $past(bus_o)));
      // R9
      self_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (cond && xchg_req && xchg_a == SEL_W'(i) && xchg_b == SEL_W'(i))
          |=> $stable(regs_o[i]));
    end
  endgenerate
endmodule

bind bus_xfer_unit bus_xfer_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .src_sel(src_sel), .bus_en(bus_en), .ld_en(ld_en),
  .cond(cond), .xchg_req(xchg_req), .xchg_a(xchg_a), .xchg_b(xchg_b),
  .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_data(ext_data),
  .bus_o(bus_o), .regs_o(regs_o)
);

// File: tb/bus_xfer_unit_tb_top.sv
module bus_xfer_unit_tb_top;
  localparam int W = 8;
  logic clk = 0, rst = 1;
  logic [1:0] src_sel = 0, xchg_a = 0, xchg_b = 0;
  logic bus_en = 0, cond = 0, xchg_req = 0, ext_valid = 0;
  logic [3:0] ld_en = 0;
  logic [W-1:0] ext_data = 0;
  logic ext_ready;
  logic [W-1:0] bus_o;
  logic [3:0][W-1:0] regs_o;
  logic [W-1:0] m [4];
  int n_chk = 0, n_bad = 0;
  logic done = 0;

  always #5 clk = ~clk;

  bus_xfer_unit #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .src_sel(src_sel), .bus_en(bus_en), .ld_en(ld_en),
    .cond(cond), .xchg_req(xchg_req), .xchg_a(xchg_a), .xchg_b(xchg_b),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_data(ext_data),
    .bus_o(bus_o), .regs_o(regs_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_bus();
    if (ext_valid && !rst) return ext_data;
    if (!bus_en) return '0;
    return m[src_sel];
  endfunction

  // Drive, check bus, clock, update model, check registers.
  task automatic cyc(string tag, logic [1:0] s, logic be, logic [3:0] ld,
                     logic c, logic xr, logic [1:0] xa, logic [1:0] xb,
                     logic ev, logic [W-1:0] ed);
    logic [W-1:0] nb;
    logic [W-1:0] nm [4];
    src_sel = s; bus_en = be; ld_en = ld; cond = c; xchg_req = xr;
    xchg_a = xa; xchg_b = xb; ext_valid = ev; ext_data = ed;
    #1;
    nb = exp_bus();
    check({tag, " bus R2 R3 R4"}, 32'(bus_o), 32'(nb));
    check({tag, " ready R4"}, 32'(ext_ready), 32'(!rst));
    for (int i = 0; i < 4; i++) begin
      if (rst) nm[i] = '0;
      else if (c && xr && (xa == 2'(i) || xb == 2'(i)))
        nm[i] = (xa == 2'(i)) ? m[xb] : m[xa];
      else if (c && ld[i]) nm[i] = nb;
      else nm[i] = m[i];
    end
    @(posedge clk);
    for (int i = 0; i < 4; i++) m[i] = nm[i];
    @(negedge clk);
    for (int i = 0; i < 4; i++) check({tag, " reg R5 R6 R7 R8 R9 R1"},
                                      32'(regs_o[i]), 32'(m[i]));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 'x;
    @(negedge clk);
    // R1: reset clears everything
    cyc("R1 rst", 0, 1, 4'hF, 1, 0, 0, 0, 1, 8'h55);
    rst = 0;
    // R4 R5: fill each register via external word
    for (int i = 0; i < 4; i++)
      cyc("R4 fill", 0, 1, 4'(1 << i), 1, 0, 0, 0, 1, 8'(8'h1F * (i + 3)));
    // R2 R3: select sweep with enable on/off
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 2; e++)
        cyc("R2 sel", 2'(s), e[0], 0, 1, 0, 0, 0, 0, 0);
    // R5 R6: every source to every destination, condition both ways
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        for (int c = 0; c < 2; c++) begin
          cyc("R4 reseed", 0, 1, 4'(1 << s), 1, 0, 0, 0, 1, 8'(s * 37 + d * 11 + 5));
          cyc("R5 R6 xfer", 2'(s), 1, 4'(1 << d), c[0], 0, 0, 0, 0, 0);
        end
    // R5: multi-destination load
    cyc("R5 multi", 2, 1, 4'b1011, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++)
      cyc("R4 distinct", 0, 1, 4'(1 << i), 1, 0, 0, 0, 1, 8'(8'hA0 + i * 7));
    // R6 R7 R8 R9: exchange sweep, with all loads and condition both ways
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++) begin
          cyc("R7 R9 xchg", 0, 1, 0, c[0], 1, 2'(a), 2'(b), 0, 0);
          cyc("R8 prio", 2'(b), 1, 4'hF, 1, 1, 2'(a), 2'(b), 1, 8'(a * 16 + b + c));
          for (int i = 0; i < 4; i++)
            cyc("R4 refill", 0, 1, 4'(1 << i), 1, 0, 0, 0, 1, 8'(8'h30 + i * 13 + a));
        end
    // R1: mid-run reset, ready low during reset
    rst = 1;
    cyc("R1 midrst", 1, 1, 4'hF, 1, 1, 0, 1, 1, 8'hEE);
    rst = 0;
    cyc("R3 after", 3, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule